// File: doc/BRIEF.md
# Control-Driven Register/ALU/Memory Datapath

This block is the execution half of a small processor, with no instruction decoder in front of it. The caller drives every control line directly, on every cycle. It contains four general registers, an ALU that also reports flags, and an internal data memory.

Each cycle performs one register transfer, and its results land on the next rising clock edge. In a single cycle the block can do any of these:

- compute on two registers, or on one register and an immediate value;
- load a memory word into a register;
- store a register into memory;
- store to memory and write back a register at the same edge.

The memory is addressed by whatever value read port A presents, and it is written with the value of read port B. The memory has as many words as a register can address.

Top module: `dp_core`

## Requirements
- R1: There are four registers of WIDTH bits, selected by 2-bit codes. `port_a` shows the register chosen by `addr_a`, and `port_b` shows the register chosen by `addr_b`, combinationally in the same cycle. Reset, which is synchronous and active high, clears every register to zero.
- R2: A register changes only at a rising edge with `reg_we`=1, and only the one chosen by `addr_d` changes. With `reg_we`=0, all four registers keep their values.
- R3: The memory holds 2^WIDTH words of WIDTH bits and is addressed by `port_a`. `mem_q` shows the addressed word asynchronously. At a rising edge with `mem_we`=1, `port_b` is stored at that address and no other word changes. Reset clears every word.
- R4: With `mem_we`=0, no memory word changes.
- R5: Register write-back data is the ALU result when `wb_sel`=0 and `mem_q` when `wb_sel`=1.
- R6: The ALU's second operand Y is `imm_in` when `imm_sel`=1 and `port_b` when `imm_sel`=0.
- R7: The arithmetic codes of `fn_sel` are as follows, with A taken from `port_a`:
  - 1: A+1
  - 2: A+Y
  - 3: A+Y+1
  - 4: A+~Y
  - 5: A+~Y+1
  - 6: A-1, computed as A plus all ones

  `flag_c` is the carry out of the WIDTH-bit addition.
- R8: The other codes of `fn_sel` are as follows:
  - 0 and 7: A
  - 8: A AND Y
  - 9: A OR Y
  - 10: A XOR Y
  - 11: NOT A
  - 12: Y
  - 13: Y shifted right by one, with zero fill
  - 14: Y shifted left by one, with zero fill
  - 15: zero

  For all of these codes, `flag_c`=0 and `flag_v`=0.
- R9: `flag_z` is 1 when the result is zero. `flag_n` equals the result's top bit. `flag_v` is 1 when an arithmetic code adds two values of equal sign and gets a sum of the other sign.
- R10: With `reg_we`=1 and `mem_we`=1 in the same cycle, both writes happen at one edge. The memory address and data are the values from before that edge.
- R11: A three-cycle sequence increments a memory word:
  1. load M[R0] into R3 (`addr_a`=0, `wb_sel`=1, `addr_d`=3, `reg_we`=1);
  2. add one to R3 (`addr_a`=3, `fn_sel`=1, `wb_sel`=0);
  3. store R3 to M[R0] (`addr_a`=0, `addr_b`=3, `mem_we`=1, `reg_we`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | rising-edge clock |
| rst | input | 1 | synchronous active-high reset |
| addr_a | input | 2 | read port A select |
| addr_b | input | 2 | read port B select |
| addr_d | input | 2 | write target select |
| reg_we | input | 1 | register write enable |
| fn_sel | input | 4 | ALU function code |
| imm_sel | input | 1 | 1: immediate replaces operand Y |
| wb_sel | input | 1 | 1: write back memory data, 0: ALU result |
| mem_we | input | 1 | memory write enable |
| imm_in | input | WIDTH | immediate operand |
| port_a | output | WIDTH | read port A data (memory address) |
| port_b | output | WIDTH | read port B data (memory write data) |
| alu_f | output | WIDTH | ALU result |
| mem_q | output | WIDTH | memory word at address `port_a` |
| flag_z | output | 1 | zero flag |
| flag_n | output | 1 | negative flag |
| flag_c | output | 1 | carry flag |
| flag_v | output | 1 | signed overflow flag |

## Verification
The assertions check four things on every cycle:

- a register write shows up on port A the next cycle, and with no register write a read port holding the same address stays stable;
- a memory store at an unchanged address shows up on `mem_q`;
- with `mem_we`=0, the word at an unchanged address stays stable;
- the state right after reset is zero.

Other behaviours only the bench's scenarios can show: the value of each ALU code and its flags, the immediate substitution, the write-back source, the simultaneous register-and-memory write with old-address semantics, and the load-increment-store sequence.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [3:0] {
        OP_PASS_A   = 4'd0,
        OP_INC      = 4'd1,
        OP_ADD      = 4'd2,
        OP_ADD_C    = 4'd3,
        OP_ADD_NY   = 4'd4,
        OP_SUB      = 4'd5,
        OP_DEC      = 4'd6,
        OP_PASS_A2  = 4'd7,
        OP_AND      = 4'd8,
        OP_OR       = 4'd9,
        OP_XOR      = 4'd10,
        OP_NOT_A    = 4'd11,
        OP_PASS_Y   = 4'd12,
        OP_SHR_Y    = 4'd13,
        OP_SHL_Y    = 4'd14,
        OP_ZERO     = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    typedef enum logic {
        WB_ALU = 1'b0,
        WB_MEM = 1'b1
    } wb_src_e;

    typedef enum logic {
        OPB_REG = 1'b0,
        OPB_IMM = 1'b1
    } opb_src_e;

    function automatic logic uses_adder(alu_op_e op);
        return (op >= OP_INC) && (op <= OP_DEC);
    endfunction

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int WIDTH = 8,
    parameter int NREG  = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra,
    input  logic [AW-1:0]    rb,
    input  logic [AW-1:0]    wa,
    input  logic             we,
    input  logic [WIDTH-1:0] wd,
    output logic [WIDTH-1:0] qa,
    output logic [WIDTH-1:0] qb
);
    logic [WIDTH-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic load;
        assign load = we && (wa == AW'(i));
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (load)
                regs[i] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] f,
    output alu_flags_t       flags
);
    logic [WIDTH-1:0] y;
    logic             cin;
    logic [WIDTH:0]   sum;
    logic             add_op;

    always_comb begin
        y   = '0;
        cin = 1'b0;
        unique case (op)
            OP_INC:    begin y = '0;      cin = 1'b1; end
            OP_ADD:    begin y = b;       cin = 1'b0; end
            OP_ADD_C:  begin y = b;       cin = 1'b1; end
            OP_ADD_NY: begin y = ~b;      cin = 1'b0; end
            OP_SUB:    begin y = ~b;      cin = 1'b1; end
            OP_DEC:    begin y = '1;      cin = 1'b0; end
            default:   begin y = '0;      cin = 1'b0; end
        endcase
    end

    assign add_op = uses_adder(op);
    assign sum    = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        unique case (op)
            OP_PASS_A, OP_PASS_A2: f = a;
            OP_AND:                f = a & b;
            OP_OR:                 f = a | b;
            OP_XOR:                f = a ^ b;
            OP_NOT_A:              f = ~a;
            OP_PASS_Y:             f = b;
            OP_SHR_Y:              f = {1'b0, b[WIDTH-1:1]};
            OP_SHL_Y:              f = {b[WIDTH-2:0], 1'b0};
            OP_ZERO:               f = '0;
            default:               f = sum[WIDTH-1:0];
        endcase
    end

    always_comb begin
        flags.z = (f == '0);
        flags.n = f[WIDTH-1];
        flags.c = add_op & sum[WIDTH];
        flags.v = add_op & (a[WIDTH-1] == y[WIDTH-1]) & (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
    parameter int WIDTH = 8,
    localparam int DEPTH = 1 << WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             we,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                mem[k] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dp_core.sv
module dp_core
    import dp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int NREG  = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [AW-1:0]    addr_d,
    input  logic             reg_we,
    input  logic [3:0]       fn_sel,
    input  logic             imm_sel,
    input  logic             wb_sel,
    input  logic             mem_we,
    input  logic [WIDTH-1:0] imm_in,
    output logic [WIDTH-1:0] port_a,
    output logic [WIDTH-1:0] port_b,
    output logic [WIDTH-1:0] alu_f,
    output logic [WIDTH-1:0] mem_q,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v
);
    logic [WIDTH-1:0] opnd_y;
    logic [WIDTH-1:0] wb_data;
    alu_flags_t       flags;

    dp_regfile #(.WIDTH(WIDTH), .NREG(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (addr_a),
        .rb  (addr_b),
        .wa  (addr_d),
        .we  (reg_we),
        .wd  (wb_data),
        .qa  (port_a),
        .qb  (port_b)
    );

    assign opnd_y = (opb_src_e'(imm_sel) == OPB_IMM) ? imm_in : port_b;

    dp_alu #(.WIDTH(WIDTH)) u_alu (
        .op    (alu_op_e'(fn_sel)),
        .a     (port_a),
        .b     (opnd_y),
        .f     (alu_f),
        .flags (flags)
    );

    dp_ram #(.WIDTH(WIDTH)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .addr  (port_a),
        .wdata (port_b),
        .we    (mem_we),
        .rdata (mem_q)
    );

    assign wb_data = (wb_src_e'(wb_sel) == WB_MEM) ? mem_q : alu_f;

    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_c = flags.c;
    assign flag_v = flags.v;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk #(
    parameter int WIDTH = 8,
    parameter int AW    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    addr_a,
    input logic [AW-1:0]    addr_d,
    input logic             reg_we,
    input logic             mem_we,
    input logic [WIDTH-1:0] port_a,
    input logic [WIDTH-1:0] port_b,
    input logic [WIDTH-1:0] mem_q,
    input logic [WIDTH-1:0] wb_data
);
    // R1: state right after reset is zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_a == '0 && port_b == '0 && mem_q == '0));

    // R2: written register shows the write-back value next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (addr_a != $past(addr_d)) || (port_a == $past(wb_data)));

    // R2: no register write keeps a re-read register stable
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> (addr_a != $past(addr_a)) || $stable(port_a));

    // R3: memory store appears at the same address
    a_r3_store_lands: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (port_a != $past(port_a)) || (mem_q == $past(port_b)));

    // R4: no store keeps the addressed word stable
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        !mem_we |=> (port_a != $past(port_a)) || $stable(mem_q));
endmodule

bind dp_core dp_core_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_a  (addr_a),
    .addr_d  (addr_d),
    .reg_we  (reg_we),
    .mem_we  (mem_we),
    .port_a  (port_a),
    .port_b  (port_b),
    .mem_q   (mem_q),
    .wb_data (wb_data)
);

// File: tb/tb_dp_core.sv
module tb_dp_core;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   addr_a = '0, addr_b = '0, addr_d = '0;
    logic         reg_we = 1'b0, imm_sel = 1'b0, wb_sel = 1'b0, mem_we = 1'b0;
    logic [3:0]   fn_sel = '0;
    logic [W-1:0] imm_in = '0;
    logic [W-1:0] port_a, port_b, alu_f, mem_q;
    logic         flag_z, flag_n, flag_c, flag_v;

    always #10 clk = ~clk;

    dp_core #(.WIDTH(W), .NREG(4)) dut (
        .clk(clk), .rst(rst), .addr_a(addr_a), .addr_b(addr_b), .addr_d(addr_d),
        .reg_we(reg_we), .fn_sel(fn_sel), .imm_sel(imm_sel), .wb_sel(wb_sel),
        .mem_we(mem_we), .imm_in(imm_in), .port_a(port_a), .port_b(port_b),
        .alu_f(alu_f), .mem_q(mem_q), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    localparam int S_PA = 0, S_PB = 1, S_MQ = 2, S_F = 3, S_FL = 4;

    typedef struct {
        string    req;
        int       sel;
        logic [W-1:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [W-1:0] observe(int sel);
        case (sel)
            S_PA:    return port_a;
            S_PB:    return port_b;
            S_MQ:    return mem_q;
            S_F:     return alu_f;
            default: return {4'b0, flag_z, flag_n, flag_c, flag_v};
        endcase
    endfunction

    // monitor: compares queued items mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it = q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual %h expected %h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, int sel, logic [W-1:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic drive(logic [1:0] aa, logic [1:0] ba, logic [1:0] da, logic we,
                         logic [3:0] fs, logic mb, logic md, logic mw, logic [W-1:0] k);
        addr_a = aa; addr_b = ba; addr_d = da; reg_we = we;
        fn_sel = fs; imm_sel = mb; wb_sel = md; mem_we = mw; imm_in = k;
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic load_imm(logic [1:0] r, logic [W-1:0] v);
        drive(2'd0, 2'd0, r, 1'b1, 4'd12, 1'b1, 1'b0, 1'b0, v);
        nxt();
    endtask

    task automatic peek_reg(string req, logic [1:0] r, logic [W-1:0] v);
        drive(r, r, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, '0);
        expect_v(req, S_PA, v);
        expect_v(req, S_PB, v);
        nxt();
    endtask

    task automatic peek_mem(string req, logic [1:0] r, logic [W-1:0] v);
        drive(r, 2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, '0);
        expect_v(req, S_MQ, v);
        nxt();
    endtask

    task automatic alu_chk(string req, logic [1:0] aa, logic [1:0] ba, logic [3:0] fs,
                           logic mb, logic [W-1:0] k, logic [W-1:0] f, logic [3:0] fl);
        drive(aa, ba, 2'd0, 1'b0, fs, mb, 1'b0, 1'b0, k);
        expect_v(req, S_F, f);
        expect_v(req, S_FL, {4'b0, fl});
        nxt();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int r = 0; r < 4; r++) peek_reg("R1 reset", 2'(r), '0);
        peek_mem("R3 reset", 2'd0, '0);

        // R6 and R2: immediate loads, ALU shows imm before edge
        drive(2'd0, 2'd0, 2'd0, 1'b1, 4'd12, 1'b1, 1'b0, 1'b0, 8'h10);
        expect_v("R6 imm pass", S_F, 8'h10);
        nxt();
        load_imm(2'd1, 8'h05);
        load_imm(2'd2, 8'h7F);
        load_imm(2'd3, 8'h80);
        peek_reg("R2 load r0", 2'd0, 8'h10);
        peek_reg("R2 load r1", 2'd1, 8'h05);
        peek_reg("R2 load r2", 2'd2, 8'h7F);
        peek_reg("R2 load r3", 2'd3, 8'h80);

        // flags order {z,n,c,v}
        alu_chk("R7 R9 add ovf", 2'd2, 2'd1, 4'd2, 1'b0, '0, 8'h84, 4'b0101);
        alu_chk("R7 add cin",    2'd2, 2'd1, 4'd3, 1'b0, '0, 8'h85, 4'b0101);
        alu_chk("R7 sub",        2'd1, 2'd2, 4'd5, 1'b0, '0, 8'h86, 4'b0100);
        alu_chk("R7 add ny",     2'd1, 2'd2, 4'd4, 1'b0, '0, 8'h85, 4'b0100);
        alu_chk("R7 inc",        2'd1, 2'd2, 4'd1, 1'b0, '0, 8'h06, 4'b0000);
        alu_chk("R7 dec carry",  2'd1, 2'd2, 4'd6, 1'b0, '0, 8'h04, 4'b0010);
        alu_chk("R9 zero carry", 2'd3, 2'd3, 4'd2, 1'b0, '0, 8'h00, 4'b1011);
        alu_chk("R8 and",        2'd1, 2'd2, 4'd8, 1'b0, '0, 8'h05, 4'b0000);
        alu_chk("R8 or",         2'd1, 2'd2, 4'd9, 1'b0, '0, 8'h7F, 4'b0000);
        alu_chk("R8 xor",        2'd1, 2'd2, 4'd10, 1'b0, '0, 8'h7A, 4'b0000);
        alu_chk("R8 not",        2'd1, 2'd2, 4'd11, 1'b0, '0, 8'hFA, 4'b0100);
        alu_chk("R8 pass a",     2'd1, 2'd2, 4'd0, 1'b0, '0, 8'h05, 4'b0000);
        alu_chk("R8 pass a2",    2'd1, 2'd2, 4'd7, 1'b0, '0, 8'h05, 4'b0000);
        alu_chk("R8 pass y",     2'd1, 2'd2, 4'd12, 1'b0, '0, 8'h7F, 4'b0000);
        alu_chk("R8 shr imm",    2'd1, 2'd2, 4'd13, 1'b1, 8'h81, 8'h40, 4'b0000);
        alu_chk("R8 shl imm",    2'd1, 2'd2, 4'd14, 1'b1, 8'h81, 8'h02, 4'b0000);
        alu_chk("R8 zero code",  2'd1, 2'd2, 4'd15, 1'b0, '0, 8'h00, 4'b1000);
        alu_chk("R6 imm operand", 2'd1, 2'd2, 4'd2, 1'b1, 8'h01, 8'h06, 4'b0000);
        alu_chk("R6 reg operand", 2'd1, 2'd2, 4'd2, 1'b0, 8'h01, 8'h84, 4'b0101);

        // R2: reg_we=0 changes nothing
        drive(2'd0, 2'd0, 2'd0, 1'b0, 4'd12, 1'b1, 1'b0, 1'b0, 8'hAA);
        nxt();
        peek_reg("R2 no write r0", 2'd0, 8'h10);
        peek_reg("R2 no write r3", 2'd3, 8'h80);

        // R3: store R2 at M[R0]
        drive(2'd0, 2'd2, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, '0);
        expect_v("R3 before store", S_MQ, 8'h00);
        nxt();
        peek_mem("R3 stored", 2'd0, 8'h7F);
        peek_mem("R3 other addr", 2'd1, 8'h00);

        // R4: mem_we=0 with other data on port B
        drive(2'd0, 2'd1, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, '0);
        nxt();
        peek_mem("R4 no store", 2'd0, 8'h7F);

        // R11 with R5: load, increment, store
        drive(2'd0, 2'd0, 2'd3, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, '0);
        nxt();
        peek_reg("R5 mem writeback", 2'd3, 8'h7F);
        drive(2'd3, 2'd0, 2'd3, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, '0);
        nxt();
        peek_reg("R5 alu writeback", 2'd3, 8'h80);
        drive(2'd0, 2'd3, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, '0);
        nxt();
        peek_mem("R11 incremented", 2'd0, 8'h80);

        // R10: R0 <- 0x20 while M[old R0=0x10] <- R1
        drive(2'd0, 2'd1, 2'd0, 1'b1, 4'd12, 1'b1, 1'b0, 1'b1, 8'h20);
        nxt();
        peek_reg("R10 reg written", 2'd0, 8'h20);
        peek_mem("R10 new addr untouched", 2'd0, 8'h00);
        load_imm(2'd2, 8'h10);
        peek_mem("R10 old addr stored", 2'd2, 8'h05);

        @(negedge clk);
        #8;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule